// File: doc/BRIEF.md
# I2C Clock Phase Timing Generator

This block generates the serial clock for an I2C master from a peripheral clock. It splits each bit period into a low half and a high half, and each half has its own 16-bit divisor field. It also produces the timing strobes that a bit engine needs. In the middle of each low half there is a drive strobe, where the engine may change SDA. In the middle of each high half there is a sample strobe, where the engine reads SDA. One-cycle ticks mark the first cycle of every phase.

Asserting the enable first opens a start window. This is one high half during which SCL stays released, so that the engine can pull SDA low in its middle. After that, normal low and high halves alternate. If a stop request is present when a low half ends, the following high half becomes a stop window, and after it SCL stays parked high. Dropping the enable returns the block to idle with SCL released. Software computes the divisors. For a combined divisor n, the intended split puts the larger half, ceil(n/2), in the high field and floor(n/2) in the low field. A stretch-hold input freezes the phase count. The integration normally ties it low.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, and from the cycle after `enable` is seen low, `scl_o` is 1 and all strobes, ticks and windows are 0.
- R2: `div_word` bits 15:0 hold the low-half divisor and bits 31:16 hold the high-half divisor.
- R3: A low half lasts 8*(low+1) clocks and a high half lasts 8*(high+1) clocks. The period is their sum.
- R4: With both divisor fields zero, each half lasts 8 clocks and the period is 16 clocks.
- R5: With the split high=ceil(n/2), low=floor(n/2), the period is 8*(n+2) clocks, and the high half is 8 clocks longer than the low half exactly when n is odd.
- R6: Both fields are captured together when a low half begins. A write at any other time does not change the current low half or the high half that follows it. A write in the cycle just before the low half begins takes effect in that low half.
- R7: `drive_stb` pulses once per low half, 4*(low+1) clocks after the low half starts.
- R8: `sample_stb` pulses once per high half, 4*(high+1) clocks after the high half starts.
- R9: When `enable` rises, a start window (`start_win`=1, SCL high) lasts 8*(high+1) clocks. `cond_stb` pulses at its offset 4*(high+1), and a low half follows.
- R10: If `stop_req` is 1 when a low half ends, the next high half is a stop window (`stop_win`=1) with `cond_stb` at its midpoint. After it, SCL stays high with no ticks or strobes until `enable` falls.
- R11: Each cycle that `stretch_hold` is 1 lengthens the current phase by one clock. The phase strobe still fires exactly once, at its midpoint count.
- R12: `fall_tick` is 1 only in the first cycle of a low half. `rise_tick` is 1 only in the first cycle of a high, start or stop phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the generator; low forces idle |
| div_word | input | 32 | Low divisor in 15:0, high divisor in 31:16 |
| stop_req | input | 1 | Turns the next high half into a stop window |
| stretch_hold | input | 1 | Freezes the phase count (normally tied low) |
| scl_o | output | 1 | SCL level, 1 = released |
| fall_tick | output | 1 | First cycle of a low half |
| rise_tick | output | 1 | First cycle of a high, start or stop phase |
| drive_stb | output | 1 | Low-half midpoint, SDA may change |
| sample_stb | output | 1 | High-half midpoint, SDA is sampled |
| cond_stb | output | 1 | Midpoint of a start or stop window |
| start_win | output | 1 | Start window in progress |
| stop_win | output | 1 | Stop window in progress |

## Verification
Two functions can fall in the same cycle. The first is a software write to `div_word`. The second is the capture of both fields at the start of a low half. The bench provokes the collision by writing a new word on the last cycle of a high half, and separately by writing a word in the middle of a high half. It then judges that the first case takes effect in the very next low half, while in the second case the current high half keeps its old length. A second collision is a stop request landing at the wrap of a low half. The bench raises the request inside that low half and checks that the following high-level phase is a stop window of the right length rather than an ordinary high half.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_LOW,
    PH_HIGH,
    PH_STOP,
    PH_PARK
  } scl_phase_e;

  // clocks in one half for a divisor field value
  function automatic int unsigned half_len(input int unsigned d);
    return (d + 1) << 3;
  endfunction

  // count value at which the midpoint strobe fires
  function automatic int unsigned half_mid(input int unsigned d);
    return (d + 1) << 2;
  endfunction

endpackage

// File: rtl/scl_div_capture.sv
module scl_div_capture #(
  parameter int DIV_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [2*DIV_W-1:0] div_word,
  output logic [DIV_W-1:0]   lo_q,
  output logic [DIV_W-1:0]   hi_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (load) begin
      lo_q <= div_word[DIV_W-1:0];
      hi_q <= div_word[2*DIV_W-1:DIV_W];
    end
  end
endmodule

// File: rtl/scl_phase_ctr.sv
module scl_phase_ctr #(
  parameter int CNT_W = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hold,
  input  logic [CNT_W-1:0] len,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic last;

  assign last = (cnt == len - CNT_W'(1));
  assign wrap = run && !hold && last;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt <= '0;
    end else if (!hold) begin
      cnt <= last ? '0 : cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
  import scl_timing_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       stop_req,
  input  logic       wrap,
  output scl_phase_e phase,
  output logic       load_div,
  output logic       new_phase
);
  scl_phase_e nxt;

  always_comb begin
    nxt = phase;
    if (!enable) begin
      nxt = PH_IDLE;
    end else begin
      case (phase)
        PH_IDLE:  nxt = PH_START;
        PH_START: if (wrap) nxt = PH_LOW;
        PH_LOW:   if (wrap) nxt = stop_req ? PH_STOP : PH_HIGH;
        PH_HIGH:  if (wrap) nxt = PH_LOW;
        PH_STOP:  if (wrap) nxt = PH_PARK;
        default:  nxt = phase;
      endcase
    end
  end

  // divisors are captured on entry to the start window and to every low half
  assign load_div = enable &&
                    ((phase == PH_IDLE) ||
                     (wrap && (phase == PH_START || phase == PH_HIGH)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      new_phase <= 1'b0;
    end else begin
      phase     <= nxt;
      new_phase <= (nxt != phase);
    end
  end
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_timing_pkg::*;
#(
  parameter int  DIV_W = 16,
  localparam int CNT_W = DIV_W + 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [2*DIV_W-1:0] div_word,
  input  logic               stop_req,
  input  logic               stretch_hold,
  output logic               scl_o,
  output logic               fall_tick,
  output logic               rise_tick,
  output logic               drive_stb,
  output logic               sample_stb,
  output logic               cond_stb,
  output logic               start_win,
  output logic               stop_win
);
  logic [DIV_W-1:0] lo_q, hi_q;
  scl_phase_e       phase;
  logic             load_div, new_phase, wrap, run, at_mid;
  logic [CNT_W-1:0] phase_cnt, phase_len, phase_mid;
  logic [CNT_W-1:0] lo_len, hi_len, lo_mid, hi_mid;
  logic             in_low, in_high_lvl;

  scl_div_capture #(.DIV_W(DIV_W)) cap_i (
    .clk(clk), .rst_n(rst_n), .load(load_div), .div_word(div_word),
    .lo_q(lo_q), .hi_q(hi_q)
  );

  scl_phase_seq seq_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .stop_req(stop_req),
    .wrap(wrap), .phase(phase), .load_div(load_div), .new_phase(new_phase)
  );

  scl_phase_ctr #(.CNT_W(CNT_W)) ctr_i (
    .clk(clk), .rst_n(rst_n), .run(run), .hold(stretch_hold),
    .len(phase_len), .cnt(phase_cnt), .wrap(wrap)
  );

  assign lo_len = CNT_W'(half_len(32'(lo_q)));
  assign hi_len = CNT_W'(half_len(32'(hi_q)));
  assign lo_mid = CNT_W'(half_mid(32'(lo_q)));
  assign hi_mid = CNT_W'(half_mid(32'(hi_q)));

  assign in_low      = (phase == PH_LOW);
  assign in_high_lvl = (phase == PH_START) || (phase == PH_HIGH) ||
                       (phase == PH_STOP);
  assign run         = enable && (in_low || in_high_lvl);

  assign phase_len = in_low ? lo_len : hi_len;
  assign phase_mid = in_low ? lo_mid : hi_mid;
  assign at_mid    = run && !stretch_hold && (phase_cnt == phase_mid);

  assign scl_o      = !in_low;
  assign fall_tick  = new_phase && in_low;
  assign rise_tick  = new_phase && in_high_lvl;
  assign drive_stb  = at_mid && in_low;
  assign sample_stb = at_mid && (phase == PH_HIGH);
  assign cond_stb   = at_mid && ((phase == PH_START) || (phase == PH_STOP));
  assign start_win  = (phase == PH_START);
  assign stop_win   = (phase == PH_STOP);
endmodule

module scl_timing_chk #(
  parameter int CNT_W = 19
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             stretch_hold,
  input logic             scl_o,
  input logic             fall_tick,
  input logic             rise_tick,
  input logic             drive_stb,
  input logic             sample_stb,
  input logic             cond_stb,
  input logic             start_win,
  input logic             stop_win,
  input logic [CNT_W-1:0] phase_cnt,
  input logic [CNT_W-1:0] phase_len
);
  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (scl_o && !drive_stb && !sample_stb && !cond_stb &&
                 !start_win && !stop_win && !fall_tick));

  assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    phase_cnt < phase_len);

  assert_len_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_o && !fall_tick) |-> $stable(phase_len));

  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({drive_stb, sample_stb, cond_stb}));

  assert_drive_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    drive_stb |-> !scl_o);

  assert_sample_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> (scl_o && !start_win && !stop_win));

  assert_window_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_win || stop_win) |-> (scl_o && !(start_win && stop_win)));

  assert_hold_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (stretch_hold && enable) |=> (scl_o == $past(scl_o)));

  assert_fall_edge_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fall_tick |-> (!scl_o && $past(scl_o)));

  assert_rise_level_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rise_tick |-> (scl_o && !fall_tick));
endmodule

bind scl_timing_gen scl_timing_chk #(.CNT_W(CNT_W)) chk_i (.*);

// File: tb/scl_timing_gen_tb.sv
module scl_timing_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [31:0] div_word = '0;
  logic        stop_req = 1'b0;
  logic        stretch_hold = 1'b0;
  logic scl_o, fall_tick, rise_tick, drive_stb, sample_stb, cond_stb;
  logic start_win, stop_win;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  scl_timing_gen dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .div_word(div_word),
    .stop_req(stop_req), .stretch_hold(stretch_hold), .scl_o(scl_o),
    .fall_tick(fall_tick), .rise_tick(rise_tick), .drive_stb(drive_stb),
    .sample_stb(sample_stb), .cond_stb(cond_stb), .start_win(start_win),
    .stop_win(stop_win)
  );

  function automatic int exp_half(input int d);
    return 8 * d + 8;
  endfunction

  function automatic int exp_mid(input int d);
    return exp_half(d) / 2;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; enable = 1'b0; stop_req = 1'b0; stretch_hold = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic quiet_check(input string tag);
    chk({tag, " scl"}, int'(scl_o), 1);
    chk({tag, " strobes/ticks/windows"},
        int'({fall_tick, rise_tick, drive_stb, sample_stb, cond_stb,
              start_win, stop_win}), 0);
  endtask

  // measures one low half plus the following high half, starting at a fall_tick
  task automatic measure(input int hold_n, input int swap_idx,
                         input logic [31:0] swap_val,
                         output int lo_n, output int hi_n,
                         output int lo_at, output int hi_at,
                         output int nd, output int ns, output int rise_at);
    int idx;
    while (!fall_tick) @(negedge clk);
    lo_at = -1; hi_at = -1; nd = 0; ns = 0; rise_at = -1;
    idx = 0;
    while (scl_o == 1'b0) begin
      if (drive_stb) begin nd++; lo_at = idx; end
      if (idx == 0 && hold_n > 0) stretch_hold = 1'b1;
      if (idx == hold_n) stretch_hold = 1'b0;
      idx++;
      @(negedge clk);
    end
    lo_n = idx;
    idx = 0;
    while (!fall_tick) begin
      if (sample_stb) begin ns++; hi_at = idx; end
      if (rise_tick) rise_at = idx;
      if (idx == swap_idx) div_word = swap_val;
      idx++;
      @(negedge clk);
    end
    hi_n = idx;
  endtask

  task automatic check_cycle(input string tag, input int lo, input int hi,
                             input int hold_n, input int swap_idx,
                             input logic [31:0] swap_val);
    int lo_n, hi_n, lo_at, hi_at, nd, ns, rise_at;
    measure(hold_n, swap_idx, swap_val, lo_n, hi_n, lo_at, hi_at, nd, ns, rise_at);
    chk({tag, " R3 low length"}, lo_n, exp_half(lo) + hold_n);
    chk({tag, " R3 high length"}, hi_n, exp_half(hi));
    chk({tag, " R7 drive offset"}, lo_at, exp_mid(lo) + hold_n);
    chk({tag, " R7 drive count"}, nd, 1);
    chk({tag, " R8 sample offset"}, hi_at, exp_mid(hi));
    chk({tag, " R8 sample count"}, ns, 1);
    chk({tag, " R12 rise tick at first high cycle"}, rise_at, 0);
  endtask

  task automatic check_start(input string tag, input int hi);
    int idx, cond_at, ncond;
    chk({tag, " R9 start window open"}, int'(start_win && scl_o && rise_tick), 1);
    idx = 0; cond_at = -1; ncond = 0;
    while (start_win) begin
      if (cond_stb) begin ncond++; cond_at = idx; end
      idx++;
      @(negedge clk);
    end
    chk({tag, " R9 start length"}, idx, exp_half(hi));
    chk({tag, " R9 cond offset"}, cond_at, exp_mid(hi));
    chk({tag, " R9 cond count"}, ncond, 1);
    chk({tag, " R9/R12 low follows with fall_tick"}, int'(fall_tick && !scl_o), 1);
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    do_reset();

    // R1 reset state
    quiet_check("R1 reset");

    // R9 start window then R3/R7/R8 normal cycle
    div_word = {16'd5, 16'd3};
    enable = 1'b1;
    @(negedge clk);
    check_start("dir", 5);
    check_cycle("dir", 3, 5, 0, -1, '0);

    // R4 zero divisors
    do_reset();
    div_word = '0;
    enable = 1'b1;
    @(negedge clk);
    check_start("R4 zero", 0);
    check_cycle("R4 zero", 0, 0, 0, -1, '0);

    // R2 field positions, widely different halves
    do_reset();
    div_word = {16'd300, 16'd5};
    enable = 1'b1;
    check_cycle("R2 layout", 5, 300, 0, -1, '0);

    // R5 odd/even split of a combined divisor
    for (int k = 0; k < 2; k++) begin
      int n, h, l, lo_n, hi_n, lo_at, hi_at, nd, ns, rise_at;
      n = (k == 0) ? 7 : 10;
      h = (n + 1) / 2;
      l = n / 2;
      do_reset();
      div_word = {16'(h), 16'(l)};
      enable = 1'b1;
      measure(0, -1, '0, lo_n, hi_n, lo_at, hi_at, nd, ns, rise_at);
      chk("R5 period", lo_n + hi_n, 8 * (n + 2));
      chk("R5 high minus low", hi_n - lo_n, 8 * (n % 2));
    end

    // R6 capture only at low start; write in the capture cycle lands at once
    do_reset();
    div_word = {16'd2, 16'd1};
    enable = 1'b1;
    check_cycle("R6 mid-high write", 1, 2, 0, 3, {16'd4, 16'd6});
    check_cycle("R6 new value", 6, 4, 0, exp_half(4) - 1, {16'd0, 16'd2});
    check_cycle("R6 last-cycle write", 2, 0, 0, -1, '0);

    // R11 stretch hold in a low half
    do_reset();
    div_word = {16'd1, 16'd2};
    enable = 1'b1;
    check_cycle("R11 hold", 2, 1, 5, -1, '0);
    check_cycle("R11 after hold", 2, 1, 0, -1, '0);

    // R10 stop window and park
    begin
      int idx, cond_at, ncond, bad;
      while (!fall_tick) @(negedge clk);
      stop_req = 1'b1;
      idx = 0;
      while (!scl_o) begin idx++; @(negedge clk); end
      chk("R10 low before stop", idx, exp_half(2));
      chk("R10 stop window open", int'(stop_win && rise_tick), 1);
      idx = 0; cond_at = -1; ncond = 0; bad = 0;
      while (stop_win) begin
        if (cond_stb) begin ncond++; cond_at = idx; end
        if (!scl_o || sample_stb) bad++;
        idx++;
        @(negedge clk);
      end
      chk("R10 stop length", idx, exp_half(1));
      chk("R10 cond offset", cond_at, exp_mid(1));
      chk("R10 cond count", ncond, 1);
      chk("R10 scl high in stop", bad, 0);
      bad = 0;
      for (int i = 0; i < 60; i++) begin
        if (!scl_o || fall_tick || rise_tick || drive_stb || sample_stb ||
            cond_stb || start_win || stop_win) bad++;
        @(negedge clk);
      end
      chk("R10 parked quiet", bad, 0);
      enable = 1'b0; stop_req = 1'b0;
      @(negedge clk);
      quiet_check("R1 after park");
    end

    // R1 disable in the middle of a low half, then R9 restart
    div_word = {16'd3, 16'd3};
    enable = 1'b1;
    while (!fall_tick) @(negedge clk);
    repeat (5) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    quiet_check("R1 mid-phase disable");
    repeat (3) @(negedge clk);
    quiet_check("R1 held idle");
    enable = 1'b1;
    @(negedge clk);
    check_start("R9 restart", 3);

    // random divisors
    for (int it = 0; it < 20; it++) begin
      int lo, hi;
      lo = int'($urandom % 24);
      hi = int'($urandom % 24);
      enable = 1'b0;
      @(negedge clk);
      div_word = {16'(hi), 16'(lo)};
      enable = 1'b1;
      @(negedge clk);
      check_start("rnd", hi);
      check_cycle("rnd", lo, hi, 0, -1, '0);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule